// File: doc/BRIEF.md
# System Control Register Block

This block is the control and status register file of a small two-core microcontroller subsystem. Software reaches it through an APB-style 32-bit slave port that decodes a 4 KB window. Every transfer completes with no wait states. The block holds several kinds of registers:

- boot-time configuration: the initial secure vector address of each core, and a per-core hold bit that keeps a core parked;
- a secure-debug status word, changed only through separate set and clear ports;
- a reset-cause word and a reset mask;
- a retention word that survives warm reset;
- a software reset request;
- read-only identification bytes.

The block drives the core hold levels, the initial vector values, one-cycle core release pulses and a one-cycle system reset request.

A parameter holds a version word. When its top nibble equals 2, an extended register set appears: clock-divider words, a security control word, a wake-control word, an interrupt-enable word and power-sense words. These registers only store and return what was written. Without the extended set their offsets behave as unmapped. Two resets exist. The asynchronous power-on reset clears everything. The synchronous warm reset restores everything except the retention word.

Top module: `scr_sysctrl`

## Requirements
- R1: After reset, these registers read as follows: 0x100 (reset cause) reads 1, 0x200 (system power sense, extended) reads 0x7F, 0x110 and 0x114 read their vector parameters, and 0x118 reads the hold parameter. Every other register reads 0. The outputs core_hold_o and the vector outputs carry the same values.
- R2: The debug status word at 0x000 is read-only. A write to 0x004 sets each bit written as 1, and a write to 0x008 clears each bit written as 1.
- R3: A write to 0x108 with bit 9 set raises sys_reset_req_o for exactly one cycle, in the cycle after the access phase. A write with bit 9 clear has no effect.
- R4: Register 0x118 stores bit 0 (core 0) and bit 1 (core 1) and drives core_hold_o. When a write changes a stored bit from 1 to 0, core_release_o pulses that bit for one cycle, in the cycle after the access. A 0-to-1 change gives no pulse.
- R5: A write to 0x110 appears on vtor0_o, and a write to 0x114 (extended only) appears on vtor1_o, in the cycle after the access.
- R6: The retention word at 0x10C keeps its value through warm reset. Warm reset returns every other register to its R1 value. Power-on reset clears the retention word to 0.
- R7: The extended set (0x00C, 0x010, 0x014, 0x018, 0x114, 0x124, 0x200, 0x20C..0x218) exists only when VERSION[31:28] == 2. Otherwise, a read of these offsets returns 0 with pslverr_o set, and a write is ignored with pslverr_o set.
- R8: Offset 0x11C is read/write in the extended variant. Otherwise a read returns 0 without error, and a write is ignored with pslverr_o set.
- R9: Offsets 0xFD0..0xFFC are read-only and return, in address order: 0x04, 0x00, 0x00, 0x00, 0x54, 0xB8, 0x0B, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R10: For a write, each byte lane whose pstrb_i bit is 0 is stored as zero.
- R11: The following accesses set pslverr_o during the access phase and change no state: a read of an unmapped offset, a read of 0x004, 0x008 or 0x108, and a write to 0x000 or to an ID offset. These reads return 0. pready_o is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| warm_rst_n | input | 1 | Synchronous warm reset, active low |
| psel_i | input | 1 | Slave select |
| penable_i | input | 1 | Access phase |
| pwrite_i | input | 1 | 1 = write |
| paddr_i | input | 12 | Byte address in the window |
| pwdata_i | input | 32 | Write data |
| pstrb_i | input | 4 | Write byte strobes |
| prdata_o | output | 32 | Read data, valid in the access phase |
| pready_o | output | 1 | Always 1 |
| pslverr_o | output | 1 | Error flag for the current access |
| core_hold_o | output | 2 | Per-core hold levels |
| core_release_o | output | 2 | One-cycle power-on-and-reset pulses |
| vtor0_o | output | 32 | Initial secure vector, core 0 |
| vtor1_o | output | 32 | Initial secure vector, core 1 |
| sys_reset_req_o | output | 1 | One-cycle system reset request |

## Verification
The hardest situation to reach is a warm reset that lands after software has changed both the retention word and the ordinary registers. Only that mix shows that the two resets separate the right state. The stimulus writes distinct patterns to the retention word, the reset mask and the reset-cause word, then pulses warm reset alone. It reads every word back, and only afterwards pulses power-on reset. A second instance built without the extended set receives the same offsets, which shows that gating by variant changes both data and error behaviour.

// File: rtl/scr_pkg.sv
package scr_pkg;
    typedef enum logic [4:0] {
        SEL_NONE, SEL_DBG_STAT, SEL_DBG_SET, SEL_DBG_CLR, SEL_SEC_CTRL,
        SEL_FDIV, SEL_SDIV, SEL_CLK_FORCE, SEL_CAUSE, SEL_RMASK, SEL_SWRST,
        SEL_RETAIN, SEL_VTOR0, SEL_VTOR1, SEL_HOLD, SEL_IRQ_EN, SEL_WAKE,
        SEL_EWAKE, SEL_PWR_SYS, SEL_PWR_RAM, SEL_ID
    } scr_sel_e;

    localparam int NCORE = 2;
    localparam int NRAM  = 4;

    typedef struct packed {
        logic [31:0]            dbg;
        logic [31:0]            cause;
        logic [31:0]            rmask;
        logic [31:0]            retain;
        logic [31:0]            vtor0;
        logic [31:0]            vtor1;
        logic [NCORE-1:0]       hold;
        logic [31:0]            wake;
        logic [31:0]            sec_ctrl;
        logic [31:0]            fdiv;
        logic [31:0]            sdiv;
        logic [31:0]            clk_force;
        logic [31:0]            irq_en;
        logic [31:0]            ewake;
        logic [31:0]            pwr_sys;
        logic [NRAM-1:0][31:0]  pwr_ram;
        logic [NCORE-1:0]       release_p;
        logic                   rst_req_p;
    } scr_state_t;
endpackage

// File: rtl/scr_decode.sv
module scr_decode
    import scr_pkg::*;
#(
    parameter bit EXT = 1'b1
) (
    input  logic [9:0] widx_i,
    output scr_sel_e   sel_o,
    output logic [1:0] ram_idx_o,
    output logic [3:0] id_idx_o
);
    localparam logic [9:0] ID_FIRST = 10'h3F4;
    localparam logic [9:0] RAM_FIRST = 10'h083;

    logic [9:0] id_off;
    logic [9:0] ram_off;

    always_comb begin
        id_off    = widx_i - ID_FIRST;
        ram_off   = widx_i - RAM_FIRST;
        id_idx_o  = id_off[3:0];
        ram_idx_o = ram_off[1:0];
        sel_o     = SEL_NONE;
        case (widx_i)
            10'h000: sel_o = SEL_DBG_STAT;
            10'h001: sel_o = SEL_DBG_SET;
            10'h002: sel_o = SEL_DBG_CLR;
            10'h003: sel_o = EXT ? SEL_SEC_CTRL  : SEL_NONE;
            10'h004: sel_o = EXT ? SEL_FDIV      : SEL_NONE;
            10'h005: sel_o = EXT ? SEL_SDIV      : SEL_NONE;
            10'h006: sel_o = EXT ? SEL_CLK_FORCE : SEL_NONE;
            10'h040: sel_o = SEL_CAUSE;
            10'h041: sel_o = SEL_RMASK;
            10'h042: sel_o = SEL_SWRST;
            10'h043: sel_o = SEL_RETAIN;
            10'h044: sel_o = SEL_VTOR0;
            10'h045: sel_o = EXT ? SEL_VTOR1     : SEL_NONE;
            10'h046: sel_o = SEL_HOLD;
            10'h047: sel_o = SEL_IRQ_EN;
            10'h048: sel_o = SEL_WAKE;
            10'h049: sel_o = EXT ? SEL_EWAKE     : SEL_NONE;
            10'h080: sel_o = EXT ? SEL_PWR_SYS   : SEL_NONE;
            10'h083, 10'h084, 10'h085, 10'h086:
                     sel_o = EXT ? SEL_PWR_RAM   : SEL_NONE;
            default: sel_o = (widx_i >= ID_FIRST) ? SEL_ID : SEL_NONE;
        endcase
    end
endmodule

// File: rtl/scr_id_rom.sv
module scr_id_rom (
    input  logic [3:0] idx_i,
    output logic [7:0] val_o
);
    always_comb begin
        case (idx_i)
            4'd0:    val_o = 8'h04;
            4'd4:    val_o = 8'h54;
            4'd5:    val_o = 8'hB8;
            4'd6:    val_o = 8'h0B;
            4'd8:    val_o = 8'h0D;
            4'd9:    val_o = 8'hF0;
            4'd10:   val_o = 8'h05;
            4'd11:   val_o = 8'hB1;
            default: val_o = 8'h00;
        endcase
    end
endmodule

// File: rtl/scr_sysctrl.sv
module scr_sysctrl
    import scr_pkg::*;
#(
    parameter logic [31:0]       VERSION   = 32'h2200_0000,
    parameter logic [NCORE-1:0]  HOLD_RST  = '0,
    parameter logic [31:0]       VTOR0_RST = 32'h1000_0000,
    parameter logic [31:0]       VTOR1_RST = 32'h1000_0000
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              warm_rst_n,
    input  logic              psel_i,
    input  logic              penable_i,
    input  logic              pwrite_i,
    input  logic [11:0]       paddr_i,
    input  logic [31:0]       pwdata_i,
    input  logic [3:0]        pstrb_i,
    output logic [31:0]       prdata_o,
    output logic              pready_o,
    output logic              pslverr_o,
    output logic [NCORE-1:0]  core_hold_o,
    output logic [NCORE-1:0]  core_release_o,
    output logic [31:0]       vtor0_o,
    output logic [31:0]       vtor1_o,
    output logic              sys_reset_req_o
);
    localparam bit EXT = (VERSION[31:28] == 4'd2);
    localparam int SWRST_BIT = 9;

    function automatic scr_state_t rst_state();
        scr_state_t s;
        s         = '0;
        s.cause   = 32'h1;
        s.vtor0   = VTOR0_RST;
        s.vtor1   = VTOR1_RST;
        s.hold    = HOLD_RST;
        s.pwr_sys = 32'h7F;
        return s;
    endfunction

    scr_state_t st_d, st_q;
    scr_sel_e   sel;
    logic [1:0] ram_idx;
    logic [3:0] id_idx;
    logic [7:0] id_val;
    logic [31:0] wmask, wval, rdata;
    logic       acc, wr, rd, err;

    scr_decode #(.EXT(EXT)) u_dec (
        .widx_i   (paddr_i[11:2]),
        .sel_o    (sel),
        .ram_idx_o(ram_idx),
        .id_idx_o (id_idx)
    );

    scr_id_rom u_id (
        .idx_i(id_idx),
        .val_o(id_val)
    );

    genvar gb;
    generate
        for (gb = 0; gb < 4; gb++) begin : g_lane
            assign wmask[8*gb +: 8] = {8{pstrb_i[gb]}};
        end
    endgenerate

    always_comb begin
        acc  = psel_i & penable_i;
        wr   = acc & pwrite_i;
        rd   = acc & ~pwrite_i;
        wval = pwdata_i & wmask;

        case (sel)
            SEL_NONE:                        err = acc;
            SEL_DBG_STAT, SEL_ID:            err = wr;
            SEL_DBG_SET, SEL_DBG_CLR,
            SEL_SWRST:                       err = rd;
            SEL_IRQ_EN:                      err = wr & ~EXT;
            default:                         err = 1'b0;
        endcase

        case (sel)
            SEL_DBG_STAT:  rdata = st_q.dbg;
            SEL_SEC_CTRL:  rdata = st_q.sec_ctrl;
            SEL_FDIV:      rdata = st_q.fdiv;
            SEL_SDIV:      rdata = st_q.sdiv;
            SEL_CLK_FORCE: rdata = st_q.clk_force;
            SEL_CAUSE:     rdata = st_q.cause;
            SEL_RMASK:     rdata = st_q.rmask;
            SEL_RETAIN:    rdata = st_q.retain;
            SEL_VTOR0:     rdata = st_q.vtor0;
            SEL_VTOR1:     rdata = st_q.vtor1;
            SEL_HOLD:      rdata = {{(32-NCORE){1'b0}}, st_q.hold};
            SEL_IRQ_EN:    rdata = EXT ? st_q.irq_en : 32'h0;
            SEL_WAKE:      rdata = st_q.wake;
            SEL_EWAKE:     rdata = st_q.ewake;
            SEL_PWR_SYS:   rdata = st_q.pwr_sys;
            SEL_PWR_RAM:   rdata = st_q.pwr_ram[ram_idx];
            SEL_ID:        rdata = {24'h0, id_val};
            default:       rdata = 32'h0;
        endcase

        st_d           = st_q;
        st_d.release_p = '0;
        st_d.rst_req_p = 1'b0;
        if (wr && !err) begin
            case (sel)
                SEL_DBG_SET:   st_d.dbg       = st_q.dbg | wval;
                SEL_DBG_CLR:   st_d.dbg       = st_q.dbg & ~wval;
                SEL_SEC_CTRL:  st_d.sec_ctrl  = wval;
                SEL_FDIV:      st_d.fdiv      = wval;
                SEL_SDIV:      st_d.sdiv      = wval;
                SEL_CLK_FORCE: st_d.clk_force = wval;
                SEL_CAUSE:     st_d.cause     = wval;
                SEL_RMASK:     st_d.rmask     = wval;
                SEL_SWRST:     st_d.rst_req_p = wval[SWRST_BIT];
                SEL_RETAIN:    st_d.retain    = wval;
                SEL_VTOR0:     st_d.vtor0     = wval;
                SEL_VTOR1:     st_d.vtor1     = wval;
                SEL_HOLD: begin
                    st_d.hold      = wval[NCORE-1:0];
                    st_d.release_p = st_q.hold & ~wval[NCORE-1:0];
                end
                SEL_IRQ_EN:    st_d.irq_en    = wval;
                SEL_WAKE:      st_d.wake      = wval;
                SEL_EWAKE:     st_d.ewake     = wval;
                SEL_PWR_SYS:   st_d.pwr_sys   = wval;
                SEL_PWR_RAM:   st_d.pwr_ram[ram_idx] = wval;
                default: ;
            endcase
        end

        if (!warm_rst_n) begin
            st_d        = rst_state();
            st_d.retain = st_q.retain;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= rst_state();
        else        st_q <= st_d;
    end

    assign prdata_o        = rd ? rdata : 32'h0;
    assign pready_o        = 1'b1;
    assign pslverr_o       = err;
    assign core_hold_o     = st_q.hold;
    assign core_release_o  = st_q.release_p;
    assign vtor0_o         = st_q.vtor0;
    assign vtor1_o         = st_q.vtor1;
    assign sys_reset_req_o = st_q.rst_req_p;

    // R4: a release pulse only follows a 1-to-0 change of the hold bit
    a_r4_release_on_fall: assert property (@(posedge clk) disable iff (!por_n)
        core_release_o[0] |-> ($past(core_hold_o[0]) && !core_hold_o[0]));

    // R3: the reset request never lasts two cycles
    a_r3_req_single: assert property (@(posedge clk) disable iff (!por_n)
        sys_reset_req_o |=> !sys_reset_req_o);

    // R11: an erroring access leaves the retention word alone
    a_r11_err_no_change: assert property (@(posedge clk) disable iff (!por_n)
        (pslverr_o && warm_rst_n) |=> $stable(st_q.retain));

    // R6: warm reset does not disturb the retention word
    a_r6_retain_warm: assert property (@(posedge clk) disable iff (!por_n)
        (!warm_rst_n) |=> $stable(st_q.retain));

    // R2: debug status changes only through its set/clear ports or warm reset
    a_r2_dbg_ports_only: assert property (@(posedge clk) disable iff (!por_n)
        (warm_rst_n && !(wr && (sel == SEL_DBG_SET || sel == SEL_DBG_CLR)))
        |=> $stable(st_q.dbg));

    // R11: no wait states
    always_comb a_r11_ready: assert (pready_o);
endmodule

// File: tb/scr_sysctrl_tb.sv
module scr_sysctrl_tb_top;
    logic clk = 1'b0;
    logic por_n = 1'b0, warm_rst_n = 1'b1;
    logic psel = 1'b0, psel_b = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [3:0]  pstrb = 4'hF;
    logic [31:0] prdata, prdata_b, vtor0, vtor1, vtor0_b, vtor1_b;
    logic pready, pready_b, perr, perr_b, rreq, rreq_b;
    logic [1:0] hold, hold_b, rel, rel_b;
    int n_chk = 0, n_bad = 0;
    logic [31:0] rv;
    logic re;

    always #5 clk = ~clk;

    scr_sysctrl #(.VERSION(32'h2000_0000), .HOLD_RST(2'b11),
                  .VTOR0_RST(32'h1000_0000), .VTOR1_RST(32'h1000_0000)) dut_i (
        .clk(clk), .por_n(por_n), .warm_rst_n(warm_rst_n),
        .psel_i(psel), .penable_i(penable), .pwrite_i(pwrite),
        .paddr_i(paddr), .pwdata_i(pwdata), .pstrb_i(pstrb),
        .prdata_o(prdata), .pready_o(pready), .pslverr_o(perr),
        .core_hold_o(hold), .core_release_o(rel), .vtor0_o(vtor0),
        .vtor1_o(vtor1), .sys_reset_req_o(rreq));

    scr_sysctrl #(.VERSION(32'h1000_0000)) dut_base_i (
        .clk(clk), .por_n(por_n), .warm_rst_n(warm_rst_n),
        .psel_i(psel_b), .penable_i(penable), .pwrite_i(pwrite),
        .paddr_i(paddr), .pwdata_i(pwdata), .pstrb_i(pstrb),
        .prdata_o(prdata_b), .pready_o(pready_b), .pslverr_o(perr_b),
        .core_hold_o(hold_b), .core_release_o(rel_b), .vtor0_o(vtor0_b),
        .vtor1_o(vtor1_b), .sys_reset_req_o(rreq_b));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic xfer(input bit base, input bit w, input logic [11:0] a,
                        input logic [31:0] d, input logic [3:0] s);
        @(negedge clk);
        psel = !base; psel_b = base; pwrite = w; paddr = a; pwdata = d; pstrb = s;
        penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        #1;
        rv = base ? prdata_b : prdata;
        re = base ? perr_b : perr;
        @(negedge clk);
        psel = 0; psel_b = 0; penable = 0; pwrite = 0;
    endtask

    task automatic wr(input bit base, input logic [11:0] a, input logic [31:0] d);
        xfer(base, 1'b1, a, d, 4'hF);
    endtask
    task automatic rdc(input bit base, input logic [11:0] a, input logic [31:0] exp,
                       input logic exp_err, input string tag);
        xfer(base, 1'b0, a, 32'h0, 4'hF);
        check(tag, rv, exp);
        check({tag, " err"}, {31'h0, re}, {31'h0, exp_err});
    endtask

    task automatic t_reset;
        rdc(0, 12'h100, 32'h1, 0, "R1 cause");
        rdc(0, 12'h200, 32'h7F, 0, "R1 pwr_sys");
        rdc(0, 12'h110, 32'h1000_0000, 0, "R1 vtor0");
        rdc(0, 12'h118, 32'h3, 0, "R1 hold");
        rdc(0, 12'h10C, 32'h0, 0, "R1 retain");
        check("R1 hold pin", {30'h0, hold}, 32'h3);
        check("R1 vtor1 pin", vtor1, 32'h1000_0000);
        check("R1 base hold", {30'h0, hold_b}, 32'h0);
    endtask

    task automatic t_debug;
        wr(0, 12'h004, 32'h0000_00F3);
        rdc(0, 12'h000, 32'hF3, 0, "R2 set");
        wr(0, 12'h008, 32'h0000_0011);
        rdc(0, 12'h000, 32'hE2, 0, "R2 clear");
        xfer(0, 1'b1, 12'h000, 32'hFFFF_FFFF, 4'hF);
        check("R2 ro write err", {31'h0, re}, 32'h1);
        rdc(0, 12'h000, 32'hE2, 0, "R2 ro unchanged");
        rdc(0, 12'h004, 32'h0, 1, "R11 read of set port");
    endtask

    task automatic t_swrst;
        wr(0, 12'h108, 32'h0000_0100);
        check("R3 no req without bit9", {31'h0, rreq}, 32'h0);
        wr(0, 12'h108, 32'h0000_0200);
        check("R3 req pulse", {31'h0, rreq}, 32'h1);
        @(negedge clk);
        check("R3 req one cycle", {31'h0, rreq}, 32'h0);
        rdc(0, 12'h108, 32'h0, 1, "R11 read of swrst");
    endtask

    task automatic t_hold;
        wr(0, 12'h118, 32'h2);
        check("R4 release core0", {30'h0, rel}, 32'h1);
        check("R4 hold after", {30'h0, hold}, 32'h2);
        @(negedge clk);
        check("R4 pulse ends", {30'h0, rel}, 32'h0);
        wr(0, 12'h118, 32'h0);
        check("R4 release core1", {30'h0, rel}, 32'h2);
        wr(0, 12'h118, 32'h3);
        check("R4 no pulse on rise", {30'h0, rel}, 32'h0);
    endtask

    task automatic t_vtor;
        wr(0, 12'h110, 32'h2000_0400);
        check("R5 vtor0 pin", vtor0, 32'h2000_0400);
        wr(0, 12'h114, 32'h3000_0800);
        check("R5 vtor1 pin", vtor1, 32'h3000_0800);
    endtask

    task automatic t_warm;
        wr(0, 12'h10C, 32'hA5A5_5A5A);
        wr(0, 12'h104, 32'h0000_00FF);
        wr(0, 12'h100, 32'h0000_0008);
        @(negedge clk); warm_rst_n = 0;
        @(negedge clk); warm_rst_n = 1;
        rdc(0, 12'h10C, 32'hA5A5_5A5A, 0, "R6 retain kept");
        rdc(0, 12'h104, 32'h0, 0, "R6 mask warm");
        rdc(0, 12'h100, 32'h1, 0, "R6 cause warm");
        check("R6 vtor0 warm", vtor0, 32'h1000_0000);
        @(negedge clk); por_n = 0;
        @(negedge clk); por_n = 1;
        rdc(0, 12'h10C, 32'h0, 0, "R6 retain por");
    endtask

    task automatic t_variant;
        wr(0, 12'h010, 32'h0000_0033);
        rdc(0, 12'h010, 32'h33, 0, "R7 ext fdiv");
        wr(0, 12'h218, 32'h0000_0044);
        rdc(0, 12'h218, 32'h44, 0, "R7 ext pwr ram3");
        xfer(1, 1'b1, 12'h010, 32'h0000_0033, 4'hF);
        check("R7 base write err", {31'h0, re}, 32'h1);
        rdc(1, 12'h010, 32'h0, 1, "R7 base read");
        rdc(1, 12'h200, 32'h0, 1, "R7 base pwr_sys");
        wr(1, 12'h114, 32'h1234_5678);
        check("R7 base vtor1 pin", vtor1_b, 32'h1000_0000);
        wr(0, 12'h11C, 32'h0000_0001);
        rdc(0, 12'h11C, 32'h1, 0, "R8 ext irq_en");
        xfer(1, 1'b1, 12'h11C, 32'h1, 4'hF);
        check("R8 base write err", {31'h0, re}, 32'h1);
        rdc(1, 12'h11C, 32'h0, 0, "R8 base reads zero");
    endtask

    task automatic t_ids;
        logic [7:0] exp_id [12] = '{8'h04, 8'h00, 8'h00, 8'h00, 8'h54, 8'hB8,
                                    8'h0B, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        for (int i = 0; i < 12; i++)
            rdc(0, 12'hFD0 + 12'(4*i), {24'h0, exp_id[i]}, 0, "R9 id");
        xfer(0, 1'b1, 12'hFE0, 32'hFF, 4'hF);
        check("R9 id write err", {31'h0, re}, 32'h1);
        rdc(0, 12'hFE0, 32'h54, 0, "R9 id unchanged");
    endtask

    task automatic t_strobe;
        xfer(0, 1'b1, 12'h10C, 32'hFFFF_FFFF, 4'b0010);
        rdc(0, 12'h10C, 32'h0000_FF00, 0, "R10 byte lane");
        xfer(0, 1'b1, 12'h104, 32'hDEAD_BEEF, 4'b1100);
        rdc(0, 12'h104, 32'hDEAD_0000, 0, "R10 half lane");
    endtask

    task automatic t_errors;
        rdc(0, 12'h300, 32'h0, 1, "R11 unmapped read");
        xfer(0, 1'b1, 12'h300, 32'h1, 4'hF);
        check("R11 unmapped write err", {31'h0, re}, 32'h1);
        check("R11 pready", {31'h0, pready}, 32'h1);
        rdc(0, 12'h10C, 32'h0000_FF00, 0, "R11 no state change");
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                por_n = 1;
                t_reset(); t_debug(); t_swrst(); t_hold(); t_vtor();
                t_warm(); t_variant(); t_ids(); t_strobe(); t_errors();
            end
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule